// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the bit-level front end of a serial-flash style slave. It watches the chip-select, serial clock, serial data input and pause pins through synchroniser stages on a faster system clock. It assembles incoming bits into bytes and passes each finished byte to a command layer on a parallel strobe interface. It also shifts response bytes from the command layer out on the serial data output, along with an output enable that stands for the tri-state control of the pin.

The same logic serves a master that parks the serial clock low between transfers and one that parks it high. A falling clock edge that comes before the first rising edge of a selection is ignored, so only the idle level of the clock differs between the two. Pulling the pause pin low while selected freezes the transfer on the current bit. Releasing the pause pin lets the transfer carry on from that bit. Raising chip-select part way through a byte throws the partial byte away and reports an abort.

Top module: `spi_flash_front`

## Requirements
- R1: Bytes are received correctly whether the serial clock idles low or idles high while chip-select is high.
- R2: Input bits are captured on rising serial-clock edges, most significant bit first, and a finished byte appears on `rx_byte`.
- R3: `rx_valid` is high for exactly one system clock per finished byte. `rx_index` gives the byte's position within the current selection: 0 for the first byte after chip-select falls, then counting up and wrapping at its width.
- R4: `tx_byte` and `tx_en` are captured at the first falling serial-clock edge after each eighth rising edge. Bit 7 of the captured byte then appears on `so_o`, and each later falling edge inside the byte moves to the next lower bit. A falling edge before the first rising edge of a selection is ignored.
- R5: `so_oe` is low while chip-select is high, while paused, and for any byte whose captured `tx_en` was 0. It is also low for the first byte of every selection.
- R6: While chip-select and `hold_n` are both low, serial-clock edges have no effect. After `hold_n` rises, reception and transmission resume at the same bit. `hold_n` has no effect while chip-select is high.
- R7: If chip-select rises with a partial byte taken in, `xfer_abort` pulses for one system clock, no `rx_valid` is produced, and the next selection starts again at byte index 0, bit 7.
- R8: After reset, `so_oe`, `rx_valid` and `xfer_abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip-select pin, active low |
| sck | input | 1 | Serial clock pin |
| si | input | 1 | Serial data input pin |
| hold_n | input | 1 | Pause pin, active low |
| so_o | output | 1 | Serial data output value |
| so_oe | output | 1 | Output enable for the serial data output (low means high impedance) |
| tx_byte | input | 8 | Response byte from the command layer |
| tx_en | input | 1 | Command layer requests that the next byte be driven |
| rx_byte | output | 8 | Last finished received byte |
| rx_valid | output | 1 | One-cycle strobe for a finished byte |
| rx_index | output | IDX_W | Position of the finished byte in the selection |
| xfer_abort | output | 1 | One-cycle pulse on deselect in the middle of a byte |

## Verification
Each pin goes through two synchroniser flops, and the edge detector and the result register add one more system clock. So `rx_valid` and a new `so_o` bit appear on the third rising system-clock edge after the pin changes, and `xfer_abort` appears on the third edge after chip-select rises. The bench holds each serial-clock phase for five system clocks. It samples `so_o` and `so_oe` just before it drives each rising edge, so every result is settled before it is read. A monitor checks `rx_valid` and `xfer_abort` on falling system-clock edges and takes expected bytes from a queue in the order the driver pushed them, so no check depends on a fixed cycle count.

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             si,
  input  logic             hold_n,
  output logic             so_o,
  output logic             so_oe,
  input  logic [7:0]       tx_byte,
  input  logic             tx_en,
  output logic [7:0]       rx_byte,
  output logic             rx_valid,
  output logic [IDX_W-1:0] rx_index,
  output logic             xfer_abort
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] cs_sync, sck_sync, si_sync, hold_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync   <= '1;
      hold_sync <= '1;
      sck_sync  <= '0;
      si_sync   <= '0;
    end else begin
      cs_sync   <= {cs_sync[LAST-1:0], cs_n};
      hold_sync <= {hold_sync[LAST-1:0], hold_n};
      sck_sync  <= {sck_sync[LAST-1:0], sck};
      si_sync   <= {si_sync[LAST-1:0], si};
    end
  end

  wire cs_s   = cs_sync[LAST];
  wire hold_s = hold_sync[LAST];
  wire sck_s  = sck_sync[LAST];
  wire si_s   = si_sync[LAST];

  logic sck_q, cs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  wire sel      = ~cs_s;
  wire held     = sel & ~hold_s;
  wire live     = sel & ~held;
  wire sck_rise = live & sck_s & ~sck_q;
  wire sck_fall = live & ~sck_s & sck_q;
  wire cs_start = sel & cs_q;
  wire cs_stop  = cs_s & ~cs_q;

  logic [2:0]       bit_cnt;
  logic [6:0]       rx_shift;
  logic [7:0]       tx_shift;
  logic [IDX_W-1:0] byte_idx;
  logic             seen_rise, drive_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      rx_shift   <= '0;
      tx_shift   <= '0;
      byte_idx   <= '0;
      seen_rise  <= 1'b0;
      drive_en   <= 1'b0;
      rx_byte    <= '0;
      rx_valid   <= 1'b0;
      rx_index   <= '0;
      xfer_abort <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      xfer_abort <= cs_stop & (bit_cnt != 3'd0);
      if (cs_start) begin
        bit_cnt   <= '0;
        byte_idx  <= '0;
        seen_rise <= 1'b0;
        drive_en  <= 1'b0;
      end else if (cs_stop) begin
        drive_en <= 1'b0;
      end else if (sck_rise) begin
        rx_shift  <= {rx_shift[5:0], si_s};
        bit_cnt   <= bit_cnt + 3'd1;
        seen_rise <= 1'b1;
        if (bit_cnt == 3'd7) begin
          rx_byte  <= {rx_shift, si_s};
          rx_valid <= 1'b1;
          rx_index <= byte_idx;
          byte_idx <= byte_idx + 1'b1;
        end
      end else if (sck_fall && seen_rise) begin
        if (bit_cnt == 3'd0) begin
          tx_shift <= tx_byte;
          drive_en <= tx_en;
        end else begin
          tx_shift <= {tx_shift[6:0], 1'b0};
        end
      end
    end
  end

  assign so_o  = tx_shift[7];
  assign so_oe = live & drive_en;
endmodule

module spi_flash_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       hold_n,
  input logic       so_oe,
  input logic       rx_valid,
  input logic       xfer_abort,
  input logic       held,
  input logic       cs_start,
  input logic [2:0] bit_cnt
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R3
  AST_ABORT_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |-> !rx_valid); // R7
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_start) |=> $stable(bit_cnt)); // R6
  AST_OE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe); // R5
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !$past(hold_n) && !$past(hold_n, 2)) |-> !so_oe); // R5
endmodule

bind spi_flash_front spi_flash_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so_oe(so_oe),
  .rx_valid(rx_valid), .xfer_abort(xfer_abort), .held(held),
  .cs_start(cs_start), .bit_cnt(bit_cnt)
);

// File: tb/spi_flash_front_bench.sv
module spi_flash_front_bench;
  localparam int IDX_W = 8;
  localparam int HALF  = 5;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sck = 0, si = 0, hold_n = 1, tx_en = 0;
  logic [7:0] tx_byte = 0;
  logic so_o, so_oe, rx_valid, xfer_abort;
  logic [7:0] rx_byte;
  logic [IDX_W-1:0] rx_index;

  int tests = 0, fails = 0, aborts = 0, byte_no = 0;
  bit done = 0;
  logic [7:0] exp_byte[$];
  int exp_idx[$];

  always #10 clk = ~clk;

  spi_flash_front #(.IDX_W(IDX_W)) u_spi_flash_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so_o(so_o), .so_oe(so_oe), .tx_byte(tx_byte), .tx_en(tx_en),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_index(rx_index),
    .xfer_abort(xfer_abort));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_byte.size() == 0) begin
        check(0, "R7 unexpected rx_valid", rx_byte, 0);
      end else begin
        logic [7:0] eb;
        int ei;
        eb = exp_byte.pop_front();
        ei = exp_idx.pop_front();
        check(rx_byte == eb, "R2 rx_byte", rx_byte, eb);
        check(int'(rx_index) == ei, "R3 rx_index", rx_index, ei);
      end
    end
    if (rst_n && xfer_abort) aborts++;
  end

  task automatic select(input bit idle_high);
    sck = idle_high;
    wclk(4);
    cs_n = 0;
    byte_no = 0;
    wclk(4);
  endtask

  task automatic deselect(input bit idle_high);
    if (!idle_high) sck = 0;
    wclk(HALF);
    cs_n = 1;
    wclk(8);
  endtask

  task automatic send_byte(input logic [7:0] mosi, input bit drive,
                           input logic [7:0] miso, input int hold_bit);
    logic [7:0] got;
    int oe_bad;
    got = 0;
    oe_bad = 0;
    tx_byte = miso;
    tx_en = drive;
    exp_byte.push_back(mosi);
    exp_idx.push_back(byte_no % (1 << IDX_W));
    for (int i = 7; i >= 0; i--) begin
      sck = 0;
      si = mosi[i];
      wclk(HALF);
      got[i] = so_o;
      if (so_oe !== drive) oe_bad++;
      sck = 1;
      wclk(HALF);
      if (i == hold_bit) begin
        hold_n = 0;
        wclk(4);
        check(so_oe == 0, "R5 so_oe during hold", so_oe, 0);
        for (int k = 0; k < 3; k++) begin
          sck = 0; wclk(3);
          sck = 1; wclk(3);
        end
        hold_n = 1;
        wclk(4);
      end
    end
    check(oe_bad == 0, "R5 so_oe per bit", oe_bad, 0);
    if (drive) check(got == miso, "R4 so_o byte", got, miso);
    byte_no++;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wclk(3);
    check(so_oe == 0, "R8 so_oe reset", so_oe, 0);
    check(rx_valid == 0, "R8 rx_valid reset", rx_valid, 0);
    check(xfer_abort == 0, "R8 abort reset", xfer_abort, 0);
    rst_n = 1;
    wclk(3);

    // R1 clock idle low
    select(0);
    send_byte(8'h9F, 0, 8'h00, -1);
    send_byte(8'h00, 1, 8'hA5, -1);
    send_byte(8'h3C, 1, 8'h5A, -1);
    deselect(0);

    // R1 clock idle high, R6 pause mid-byte
    select(1);
    send_byte(8'h03, 0, 8'h00, -1);
    send_byte(8'hFF, 1, 8'h81, 4);
    send_byte(8'h12, 1, 8'h7E, -1);
    send_byte(8'hE7, 0, 8'h00, 2);
    deselect(1);

    // R7 early deselect after three bits
    select(0);
    for (int i = 0; i < 3; i++) begin
      sck = 0; si = 1; wclk(HALF);
      sck = 1; wclk(HALF);
    end
    deselect(0);
    check(aborts == 1, "R7 abort pulse", aborts, 1);
    select(0);
    send_byte(8'hC3, 0, 8'h00, -1);
    send_byte(8'h18, 1, 8'hC0, -1);
    deselect(0);
    check(aborts == 1, "R7 no abort on clean end", aborts, 1);

    // R6 pause pin and clock activity while deselected
    sck = 1;
    hold_n = 0;
    wclk(4);
    for (int k = 0; k < 3; k++) begin
      sck = 0; wclk(3); sck = 1; wclk(3);
    end
    hold_n = 1;
    wclk(4);
    check(so_oe == 0, "R5 so_oe deselected", so_oe, 0);
    select(1);
    send_byte(8'h66, 0, 8'h00, -1);
    deselect(1);

    wclk(10);
    check(exp_byte.size() == 0, "R3 all bytes strobed", exp_byte.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule